// File: doc/BRIEF.md
# Exception State Capture Registers

This block keeps the exception bookkeeping of a system control coprocessor. It holds four architectural registers: a processor status word, an exception cause word, the exception return address and the faulting virtual address. It also holds a fixed identification word that reads as a constant. When the pipeline raises an exception, the block records the 5-bit cause code. It also saves the program counter of the faulting instruction. For TLB-miss and address-error faults it further saves the data address that failed.

The block samples eight hardware interrupt lines into the pending field of the cause word on every clock. It raises an interrupt request while interrupts are globally enabled and any pending line is unmasked. Software reaches the registers through a move-to/move-from port that is qualified by a kernel-mode flag. A move attempted outside kernel mode is not carried out. Instead it becomes a coprocessor-unusable exception.

The move port is a valid-only stream that is always accepted: there is no ready and no back-pressure. A move that is presented completes in the cycle it is presented. A move-from returns its data combinationally in the same cycle. A move-to becomes visible on the next cycle.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, status (index 12), cause (index 13), EPC (index 14) and BadVAddr (index 8) all read 0, and irq_req is low.
- R2: On exc_valid, cause bits 6:2 hold exc_code from the next cycle on. The other cause bits keep their own behaviour.
- R3: On exc_valid, EPC holds exc_pc from the next cycle on.
- R4: BadVAddr takes exc_vaddr only when exc_code is 2, 3, 4 or 5. Any other code, including 1, leaves BadVAddr unchanged.
- R5: A kernel move-to of index 12 stores bit 0 (global enable), bits 15:8 (mask IM7..IM0) and bit 25 (reverse endian). Every other status bit reads 0.
- R6: A kernel move-to of index 14 replaces EPC. A move-to of index 13, 8 or 15 changes nothing that can be read back.
- R7: A kernel move-from returns the selected register: 8, 12, 13, 14, or 15 (the PRID_VALUE constant). Any other index returns 0, and mv_rdata is 0 whenever no read is carried out.
- R8: Cause bits 15:8 (IP7..IP0) show hw_irq as sampled at the previous clock edge. Cause bits 7, 1:0 and 31:16 read 0.
- R9: irq_req is high exactly when status bit 0 is set and some cause pending bit is set whose status mask bit (15:8) is also set.
- R10: A move with kernel_mode low does no access: priv_fault is high in that cycle, mv_rdata is 0, status is unchanged, and next cycle cause code is 11 and EPC holds mv_pc.
- R11: When exc_valid and mv_valid are high together, the exception is recorded, the move is dropped, and priv_fault stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | Pipeline exception strobe |
| exc_code | input | 5 | Cause code of the exception |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_vaddr | input | 32 | Faulting data virtual address |
| hw_irq | input | 8 | Hardware interrupt lines |
| mv_valid | input | 1 | Register move request |
| mv_write | input | 1 | 1 = move-to, 0 = move-from |
| mv_sel | input | 5 | Register index |
| mv_wdata | input | 32 | Move-to data |
| mv_pc | input | 32 | Address of the move instruction |
| kernel_mode | input | 1 | Processor is in kernel mode |
| mv_rdata | output | 32 | Move-from data |
| priv_fault | output | 1 | Move refused, coprocessor-unusable raised |
| irq_req | output | 1 | Unmasked interrupt pending and enabled |

## Verification
The bench targets the BadVAddr boundary at codes 1 and 6, the two codes just outside the address-fault range. A design with an off-by-one range test would overwrite the saved address on a TLB-modified or bus-error fault.

It collides an exception with a kernel status write in the same cycle. A design with the wrong priority would let the write land, or would flag a privilege fault.

It issues user-mode moves to registers that accept writes. A design that leaks the write would corrupt status, or would fail to record code 11 and the move's PC.

It also writes to read-only indices and checks irq_req against mask, enable and one-cycle-late pending bits. An ungated enable or a missing sample register shows up as an interrupt request in the wrong cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned CODE_W  = 5;

  // register indices decoded by the move port
  localparam logic [SEL_W-1:0] IDX_BADVA  = 5'd8;
  localparam logic [SEL_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] IDX_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] IDX_EPC    = 5'd14;
  localparam logic [SEL_W-1:0] IDX_PRID   = 5'd15;

  // field positions
  localparam int unsigned ST_IE_BIT  = 0;
  localparam int unsigned ST_RE_BIT  = 25;
  localparam int unsigned IM_LSB     = 8;
  localparam int unsigned IP_LSB     = 8;
  localparam int unsigned CODE_LSB   = 2;

  typedef enum logic [CODE_W-1:0] {
    EC_INT     = 5'd0,
    EC_TLB_MOD = 5'd1,
    EC_TLB_LD  = 5'd2,
    EC_TLB_ST  = 5'd3,
    EC_ADR_LD  = 5'd4,
    EC_ADR_ST  = 5'd5,
    EC_IBUS    = 5'd6,
    EC_DBUS    = 5'd7,
    EC_SYS     = 5'd8,
    EC_BRK     = 5'd9,
    EC_RESV    = 5'd10,
    EC_CPU     = 5'd11,
    EC_OVF     = 5'd12,
    EC_TRAP    = 5'd13,
    EC_FPE     = 5'd15,
    EC_C2E     = 5'd16,
    EC_WATCH   = 5'd23
  } exc_code_e;

  function automatic logic saves_vaddr(input logic [CODE_W-1:0] code);
    return (code >= EC_TLB_LD) && (code <= EC_ADR_ST);
  endfunction

endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_ie,
  input  logic [NUM_IRQ-1:0] wr_im,
  input  logic               wr_re,
  output logic [REG_W-1:0]   status_o,
  output logic [NUM_IRQ-1:0] im_o,
  output logic               ie_o
);

  logic               ie_q;
  logic               re_q;
  logic [NUM_IRQ-1:0] im_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      re_q <= 1'b0;
      im_q <= '0;
    end else if (wr_en) begin
      ie_q <= wr_ie;
      re_q <= wr_re;
      im_q <= wr_im;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ST_IE_BIT] = ie_q;
    status_o[ST_RE_BIT] = re_q;
    status_o[IM_LSB +: NUM_IRQ] = im_q;
  end

  assign im_o = im_q;
  assign ie_o = ie_q;

  // R5
  status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (im_o == $past(wr_im)) && (ie_o == $past(wr_ie))
              && (status_o[ST_RE_BIT] == $past(wr_re)));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_o));

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IRQ-1:0] hw_irq,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  output logic [REG_W-1:0]  cause_o,
  output logic [NUM_IRQ-1:0] ip_o
);

  logic [NUM_IRQ-1:0] ip_q;
  logic [CODE_W-1:0]  code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q   <= '0;
      code_q <= '0;
    end else begin
      ip_q <= hw_irq;
      if (take) code_q <= take_code;
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[IP_LSB +: NUM_IRQ]  = ip_q;
    cause_o[CODE_LSB +: CODE_W] = code_q;
  end

  assign ip_o = ip_q;

  // R2
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cause_o[CODE_LSB +: CODE_W] == $past(take_code));

  // R8
  cause_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ip_o == $past(hw_irq));

endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic [REG_W-1:0]  take_pc,
  input  logic [REG_W-1:0]  take_vaddr,
  input  logic              epc_wr,
  input  logic [REG_W-1:0]  epc_wdata,
  output logic [REG_W-1:0]  epc_o,
  output logic [REG_W-1:0]  badva_o
);

  logic [REG_W-1:0] epc_q;
  logic [REG_W-1:0] badva_q;
  logic             grab_va;

  assign grab_va = take && saves_vaddr(take_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      badva_q <= '0;
    end else begin
      if (take)        epc_q <= take_pc;
      else if (epc_wr) epc_q <= epc_wdata;
      if (grab_va)     badva_q <= take_vaddr;
    end
  end

  assign epc_o   = epc_q;
  assign badva_o = badva_q;

  // R3
  epc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc_o == $past(take_pc));

  // R4
  badva_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (take_code >= 5'd2) && (take_code <= 5'd5)) |=> badva_o == $past(take_vaddr));

  // R4
  badva_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && (take_code >= 5'd2) && (take_code <= 5'd5)) |=> $stable(badva_o));

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 8,
  parameter logic [31:0] PRID_VALUE = 32'h0001_9300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [4:0]         exc_code,
  input  logic [31:0]        exc_pc,
  input  logic [31:0]        exc_vaddr,
  input  logic [NUM_IRQ-1:0] hw_irq,
  input  logic               mv_valid,
  input  logic               mv_write,
  input  logic [4:0]         mv_sel,
  input  logic [31:0]        mv_wdata,
  input  logic [31:0]        mv_pc,
  input  logic               kernel_mode,
  output logic [31:0]        mv_rdata,
  output logic               priv_fault,
  output logic               irq_req
);

  logic              mv_ok;
  logic              mv_wr;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic [REG_W-1:0]  take_pc;
  logic [REG_W-1:0]  status_w;
  logic [REG_W-1:0]  cause_w;
  logic [REG_W-1:0]  epc_w;
  logic [REG_W-1:0]  badva_w;
  logic [NUM_IRQ-1:0] im_w;
  logic [NUM_IRQ-1:0] ip_w;
  logic [NUM_IRQ-1:0] hot_w;
  logic              ie_w;

  // pipeline exception outranks any move in the same cycle
  assign priv_fault = mv_valid && !kernel_mode && !exc_valid;
  assign mv_ok      = mv_valid && kernel_mode && !exc_valid;
  assign mv_wr      = mv_ok && mv_write;
  assign take       = exc_valid || priv_fault;
  assign take_code  = exc_valid ? exc_code : EC_CPU;
  assign take_pc    = exc_valid ? exc_pc : mv_pc;

  exc_status_reg #(.NUM_IRQ(NUM_IRQ)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mv_wr && (mv_sel == IDX_STATUS)),
    .wr_ie    (mv_wdata[ST_IE_BIT]),
    .wr_im    (mv_wdata[IM_LSB +: NUM_IRQ]),
    .wr_re    (mv_wdata[ST_RE_BIT]),
    .status_o (status_w),
    .im_o     (im_w),
    .ie_o     (ie_w)
  );

  exc_cause_reg #(.NUM_IRQ(NUM_IRQ)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_irq    (hw_irq),
    .take      (take),
    .take_code (take_code),
    .cause_o   (cause_w),
    .ip_o      (ip_w)
  );

  exc_addr_capture u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_code  (take_code),
    .take_pc    (take_pc),
    .take_vaddr (exc_vaddr),
    .epc_wr     (mv_wr && (mv_sel == IDX_EPC)),
    .epc_wdata  (mv_wdata),
    .epc_o      (epc_w),
    .badva_o    (badva_w)
  );

  // per-line gating of pending against mask
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_gate
    assign hot_w[g] = ip_w[g] & im_w[g];
  end

  assign irq_req = ie_w && (|hot_w);

  always_comb begin
    mv_rdata = '0;
    if (mv_ok && !mv_write) begin
      case (mv_sel)
        IDX_BADVA:  mv_rdata = badva_w;
        IDX_STATUS: mv_rdata = status_w;
        IDX_CAUSE:  mv_rdata = cause_w;
        IDX_EPC:    mv_rdata = epc_w;
        IDX_PRID:   mv_rdata = PRID_VALUE;
        default:    mv_rdata = '0;
      endcase
    end
  end

  // R10
  priv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !kernel_mode && !exc_valid) |=> (cause_w[CODE_LSB +: CODE_W] == 5'd11)
                                                 && (epc_w == $past(mv_pc)));

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> status_w[ST_IE_BIT]);

  // R11
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && mv_valid && mv_write && mv_sel == IDX_STATUS) |=> $stable(status_w));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_valid |-> mv_rdata == '0);

endmodule

// File: tb/sim_exc_state_regs.sv
`timescale 1ns/1ps
module sim_exc_state_regs;

  localparam logic [31:0] PRID = 32'h0001_9300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic [31:0] exc_vaddr = '0;
  logic [7:0]  hw_irq = '0;
  logic        mv_valid = 1'b0;
  logic        mv_write = 1'b0;
  logic [4:0]  mv_sel = '0;
  logic [31:0] mv_wdata = '0;
  logic [31:0] mv_pc = '0;
  logic        kernel_mode = 1'b1;
  logic [31:0] mv_rdata;
  logic        priv_fault;
  logic        irq_req;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_ie, m_re;
  logic [7:0] m_im, m_ip;
  logic [4:0] m_code;
  logic [31:0] m_epc, m_bad;

  always #2.5 clk = ~clk;

  exc_state_regs #(.NUM_IRQ(8), .PRID_VALUE(PRID)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_vaddr(exc_vaddr), .hw_irq(hw_irq),
    .mv_valid(mv_valid), .mv_write(mv_write), .mv_sel(mv_sel),
    .mv_wdata(mv_wdata), .mv_pc(mv_pc), .kernel_mode(kernel_mode),
    .mv_rdata(mv_rdata), .priv_fault(priv_fault), .irq_req(irq_req)
  );

  function automatic logic [31:0] model_read(input logic [4:0] sel);
    logic [31:0] v = '0;
    case (sel)
      5'd8:  v = m_bad;
      5'd12: begin v[0] = m_ie; v[25] = m_re; v[15:8] = m_im; end
      5'd13: begin v[15:8] = m_ip; v[6:2] = m_code; end
      5'd14: v = m_epc;
      5'd15: v = PRID;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply the current input values for one cycle, check, then advance the model
  task automatic tick(input string tag);
    logic [31:0] e_rd;
    logic        e_pf;
    @(negedge clk);
    #1;
    e_pf = mv_valid && !kernel_mode && !exc_valid;
    e_rd = (mv_valid && kernel_mode && !exc_valid && !mv_write) ? model_read(mv_sel) : 32'h0;
    chk({tag, " rdata"}, mv_rdata, e_rd);
    chk({tag, " priv_fault"}, {31'b0, priv_fault}, {31'b0, e_pf});
    chk({tag, " irq_req"}, {31'b0, irq_req}, {31'b0, m_ie && |(m_ip & m_im)});
    @(posedge clk);
    if (exc_valid) begin
      m_code = exc_code;
      m_epc  = exc_pc;
      if (exc_code >= 5'd2 && exc_code <= 5'd5) m_bad = exc_vaddr;
    end else if (e_pf) begin
      m_code = 5'd11;
      m_epc  = mv_pc;
    end else if (mv_valid && mv_write) begin
      if (mv_sel == 5'd12) begin
        m_ie = mv_wdata[0]; m_re = mv_wdata[25]; m_im = mv_wdata[15:8];
      end else if (mv_sel == 5'd14) begin
        m_epc = mv_wdata;
      end
    end
    m_ip = hw_irq;
    #0.5;
    exc_valid = 1'b0;
    mv_valid  = 1'b0;
  endtask

  task automatic rd(input logic [4:0] sel, input string tag);
    mv_valid = 1'b1; mv_write = 1'b0; mv_sel = sel; kernel_mode = 1'b1;
    tick(tag);
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d, input logic km, input string tag);
    mv_valid = 1'b1; mv_write = 1'b1; mv_sel = sel; mv_wdata = d; kernel_mode = km;
    mv_pc = 32'h8000_0000 ^ d;
    tick(tag);
  endtask

  task automatic exc(input logic [4:0] code, input logic [31:0] pc, input logic [31:0] va, input string tag);
    exc_valid = 1'b1; exc_code = code; exc_pc = pc; exc_vaddr = va;
    tick(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    m_ie = 0; m_re = 0; m_im = 0; m_ip = 0; m_code = 0; m_epc = 0; m_bad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(5'd12, "R1 status");
    rd(5'd13, "R1 cause");
    rd(5'd14, "R1 epc");
    rd(5'd8,  "R1 badvaddr");

    // R5 writable status bits only
    wr(5'd12, 32'hFFFF_FFFF, 1'b1, "R5 write");
    rd(5'd12, "R5 readback");
    chk("R5 status value", model_read(5'd12), 32'h0200_FF01);

    // R8 pending lines, R9 interrupt request
    hw_irq = 8'h24;
    tick("R8 sample");
    rd(5'd13, "R8 cause ip");
    tick("R9 irq high");
    wr(5'd12, 32'h0000_0301, 1'b1, "R9 mask off");
    tick("R9 irq masked");
    wr(5'd12, 32'h0000_2400, 1'b1, "R9 ie clear");
    tick("R9 ie low");
    hw_irq = 8'h00;

    // R2 R3 R4 capture of code, pc and vaddr
    exc(5'd2, 32'h0040_0010, 32'h1000_0004, "R4 tlb load");
    rd(5'd8,  "R4 badvaddr set");
    rd(5'd13, "R2 cause code");
    rd(5'd14, "R3 epc");
    exc(5'd1, 32'h0040_0020, 32'hDEAD_0000, "R4 tlb mod");
    rd(5'd8,  "R4 badvaddr kept code1");
    exc(5'd6, 32'h0040_0030, 32'hBEEF_0000, "R4 ibus");
    rd(5'd8,  "R4 badvaddr kept code6");
    exc(5'd5, 32'h0040_0040, 32'h0000_0003, "R4 adr store");
    rd(5'd8,  "R4 badvaddr code5");
    exc(5'd23, 32'h0040_0050, 32'h1111_1111, "R2 watch");
    rd(5'd13, "R2 cause watch");

    // R6 write effects
    wr(5'd13, 32'hFFFF_FFFF, 1'b1, "R6 cause write");
    rd(5'd13, "R6 cause kept");
    wr(5'd8, 32'h1234_5678, 1'b1, "R6 badva write");
    rd(5'd8, "R6 badva kept");
    wr(5'd15, 32'h0, 1'b1, "R6 prid write");
    rd(5'd15, "R6 prid kept");
    wr(5'd14, 32'hCAFE_0004, 1'b1, "R6 epc write");
    rd(5'd14, "R6 epc readback");

    // R7 decode
    rd(5'd3,  "R7 unmapped");
    rd(5'd31, "R7 unmapped high");
    rd(5'd15, "R7 prid");

    // R10 user mode access
    wr(5'd12, 32'h0000_FF01, 1'b0, "R10 user write");
    rd(5'd12, "R10 status kept");
    rd(5'd13, "R10 code 11");
    rd(5'd14, "R10 epc");
    mv_valid = 1'b1; mv_write = 1'b0; mv_sel = 5'd14; kernel_mode = 1'b0; mv_pc = 32'h0000_7770;
    tick("R10 user read");
    rd(5'd14, "R10 epc read fault");

    // R11 collision
    exc_valid = 1'b1; exc_code = 5'd8; exc_pc = 32'h0000_0100; exc_vaddr = 32'h5;
    mv_valid = 1'b1; mv_write = 1'b1; mv_sel = 5'd12; mv_wdata = 32'h0000_FF01; kernel_mode = 1'b1;
    tick("R11 collide write");
    rd(5'd12, "R11 status kept");
    rd(5'd13, "R11 code");
    exc_valid = 1'b1; exc_code = 5'd9; exc_pc = 32'h0000_0200;
    mv_valid = 1'b1; mv_write = 1'b0; mv_sel = 5'd13; kernel_mode = 1'b0;
    tick("R11 collide user");
    rd(5'd14, "R11 epc");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      hw_irq = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      exc_valid = (r < 12);
      exc_code = 5'($urandom);
      exc_pc = $urandom;
      exc_vaddr = $urandom;
      mv_valid = ($urandom_range(0, 1) == 1);
      mv_write = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: mv_sel = 5'd8;
        1: mv_sel = 5'd12;
        2: mv_sel = 5'd13;
        3: mv_sel = 5'd14;
        4: mv_sel = 5'd15;
        default: mv_sel = 5'($urandom);
      endcase
      mv_wdata = $urandom;
      mv_pc = $urandom;
      kernel_mode = ($urandom_range(0, 7) != 0);
      tick("R7 R9 R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule